// File: doc/BRIEF.md
# Pipelined Burst SRAM With Byte Lanes

This block is a synchronous static memory with a one-cycle command interface. On every clock edge that the active-low clock enable lets through, it decodes a command: a load cycle samples the address, three chip-select lines and a read/write flag. An advance cycle instead steps an internal burst address and repeats the operation type captured at the last load. Reads and writes run through a two-edge pipeline, so the data for a command always sits on the bus two enabled edges after the command. Reads and writes can therefore be mixed back to back with no idle turnaround cycle.

The word is split into byte lanes, 9 bits each by default, and each lane has its own active-low write enable. These enables are sampled again on every write beat of a burst. A burst walks the low two address bits in either linear or interleaved order, chosen by a static mode input. An asynchronous output enable gates the read bus. A snooze input parks the block in a quiet state: it drops every command in flight and keeps the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: When `clk_en_n` is 1 at a rising edge, that edge is ignored. No pipeline, burst or output state changes, and `rvalid`/`rdata` keep their values as long as `oe_n` and `snooze` are unchanged.
- R2: On a load cycle (`adv_ld`=0), the block is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. Any other pattern issues no operation and leaves no burst active, so the advance cycles that follow issue nothing either.
- R3: A selected load with `rd_wr`=1 reads the word at `addr`. After the second enabled edge following the command, `rdata` holds that word with `rvalid`=1.
- R4: A selected load with `rd_wr`=0 writes the word on `wdata` as it stands at the second enabled edge after the command. Bit `bwe_n[i]`=0 enables lane i (lane 0 is bits 8:0 and lane 1 is bits 17:9), and a disabled lane keeps its old contents.
- R5: An advance cycle (`adv_ld`=1) after a selected load continues the burst with the same operation type. `rd_wr` and the chip-select lines are ignored on advance cycles.
- R6: Beat n of a burst (n counts 1, 2, 3, then wraps to 0) keeps the upper address bits of the load address. Its low two bits are (base+n) mod 4 when `order_lin`=1, and base XOR n when `order_lin`=0.
- R7: `bwe_n` is sampled again on every write beat of a burst, and each beat is masked by its own sample.
- R8: `rvalid` is 1 only when the pipeline output holds read data, `oe_n`=0 and `snooze`=0. `oe_n` acts with no clock edge. While `rvalid`=0, `rdata` is all zeros.
- R9: While `snooze`=1, commands are ignored, the operations in the pipeline are discarded and no write reaches the array. The stored words are retained. A burst cannot be continued after snooze.
- R10: A read issued on the enabled edge right after a write to the same address returns the newly written lanes, merged with the unwritten lanes' old contents.
- R11: `rst`=1 at a rising edge clears the pipeline and the burst state, so `rvalid`=0 follows. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; 1 masks the edge |
| addr | input | AW | Word address, sampled on load cycles |
| ce0_n | input | 1 | Chip select, must be 0 to select |
| ce1 | input | 1 | Chip select, must be 1 to select |
| ce2_n | input | 1 | Chip select, must be 0 to select |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| rd_wr | input | 1 | On load: 1 = read, 0 = write |
| bwe_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| snooze | input | 1 | Low-power hold; drops commands, keeps data |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after its command |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rvalid | output | 1 | Read bus driven with valid data |

## Verification
The collision that matters is a write finishing in the array on the same edge that a read of that same address is issued to the array. This happens whenever a read command follows a write command to one address on the next enabled edge. The bench provokes it on purpose with random partial lane masks, and it also arises in the random mix phase, where masked clock edges fall between the two commands. A behavioural model applies every write before any later read and defines the correct result that way. The read data is judged against this model on every cycle, so a stale lane or a wrongly merged lane shows up as a mismatch in `rdata`.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Number of address bits that a burst walks through.
  localparam int BEAT_BITS = 2;

  // Low address bits of a burst beat: linear adds the step, interleaved XORs it.
  function automatic logic [BEAT_BITS-1:0] beat_lo(
    input logic [BEAT_BITS-1:0] base,
    input logic [BEAT_BITS-1:0] step,
    input logic                 lin
  );
    logic [BEAT_BITS-1:0] sum;
    sum = base + step;
    return lin ? sum : (base ^ step);
  endfunction

endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          flush,
  input  logic          load,
  input  logic          order_lin,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] beat_addr
);
  import sbs_pkg::*;

  logic [AW-1:0]        base_q;
  logic [BEAT_BITS-1:0] step_q;
  logic [BEAT_BITS-1:0] step_nx;

  assign step_nx = step_q + 1'b1;

  // Address of this cycle's beat: the fresh address on a load, else the next step.
  always_comb begin
    if (load) begin
      beat_addr = addr_in;
    end else begin
      beat_addr = {base_q[AW-1:BEAT_BITS],
                   beat_lo(base_q[BEAT_BITS-1:0], step_nx, order_lin)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      base_q <= '0;
      step_q <= '0;
    end else if (en) begin
      if (load) begin
        base_q <= addr_in;
        step_q <= '0;
      end else begin
        step_q <= step_nx;
      end
    end
  end

endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Simple dual-port array with a registered read; a colliding read sees old data.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic [AW-1:0]           addr,
  input  logic                    ce0_n,
  input  logic                    ce1,
  input  logic                    ce2_n,
  input  logic                    adv_ld,
  input  logic                    rd_wr,
  input  logic [LANES-1:0]        bwe_n,
  input  logic                    oe_n,
  input  logic                    order_lin,
  input  logic                    snooze,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DW = LANES * LANE_W;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [LANES-1:0] be;
    logic [AW-1:0]    addr;
  } stage_t;

  logic          step_en;
  logic          ram_en;
  logic          is_load;
  logic          chip_sel;
  logic [AW-1:0] beat_addr;

  stage_t s1_d, s1_q, s2_q;
  logic   bur_act_q, bur_wr_q;
  logic   out_vld_q;
  logic [DW-1:0] out_q;
  logic [DW-1:0] ram_q;
  logic [DW-1:0] merged;

  logic             fwd_hit_q;
  logic [LANES-1:0] fwd_be_q;
  logic [DW-1:0]    fwd_data_q;

  assign step_en  = !clk_en_n;
  assign ram_en   = !clk_en_n && !snooze && !rst;
  assign is_load  = !adv_ld;
  assign chip_sel = !ce0_n && ce1 && !ce2_n;

  sbs_burst_gen #(.AW(AW)) burst_i (
    .clk       (clk),
    .rst       (rst),
    .en        (step_en),
    .flush     (snooze),
    .load      (is_load),
    .order_lin (order_lin),
    .addr_in   (addr),
    .beat_addr (beat_addr)
  );

  // Command decode: a load takes its selection and type from the pins,
  // an advance inherits both from the burst registers.
  always_comb begin
    s1_d.vld  = is_load ? chip_sel : bur_act_q;
    s1_d.wr   = is_load ? !rd_wr   : bur_wr_q;
    s1_d.be   = ~bwe_n;
    s1_d.addr = beat_addr;
  end

  always_ff @(posedge clk) begin
    if (rst || snooze) begin
      s1_q      <= '0;
      s2_q      <= '0;
      bur_act_q <= 1'b0;
      bur_wr_q  <= 1'b0;
      out_vld_q <= 1'b0;
      fwd_hit_q <= 1'b0;
    end else if (step_en) begin
      s1_q <= s1_d;
      s2_q <= s1_q;
      if (is_load) begin
        bur_act_q <= chip_sel;
        bur_wr_q  <= !rd_wr;
      end
      out_vld_q <= s2_q.vld && !s2_q.wr;
      // Read entering the array while a write to the same word leaves it.
      fwd_hit_q <= s1_q.vld && !s1_q.wr && s2_q.vld && s2_q.wr &&
                   (s1_q.addr == s2_q.addr);
    end
  end

  // Data-path registers without reset, for block RAM friendly packing.
  always_ff @(posedge clk) begin
    if (ram_en) begin
      fwd_be_q   <= s2_q.be;
      fwd_data_q <= wdata;
      out_q      <= merged;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_we;
    assign lane_we = s2_q.vld && s2_q.wr && s2_q.be[l];

    sbs_lane_ram #(.AW(AW), .W(LANE_W)) ram_i (
      .clk   (clk),
      .en    (ram_en),
      .we    (lane_we),
      .waddr (s2_q.addr),
      .wdata (wdata[l*LANE_W +: LANE_W]),
      .raddr (s1_q.addr),
      .rdata (ram_q[l*LANE_W +: LANE_W])
    );

    assign merged[l*LANE_W +: LANE_W] = (fwd_hit_q && fwd_be_q[l]) ?
                                        fwd_data_q[l*LANE_W +: LANE_W] :
                                        ram_q[l*LANE_W +: LANE_W];
  end

  assign rvalid = out_vld_q && !oe_n && !snooze;
  assign rdata  = rvalid ? out_q : '0;

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en_n,
  input logic          snooze,
  input logic          adv_ld,
  input logic          ce0_n,
  input logic          ce1,
  input logic          ce2_n,
  input logic          oe_n,
  input logic          rvalid,
  input logic [DW-1:0] rdata,
  input logic          s1_vld,
  input logic          s2_vld,
  input logic          out_vld
);

  AST_OE_BLOCKS_BUS: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rvalid); // R8

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0)); // R8

  AST_SNOOZE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    snooze |=> (!s1_vld && !s2_vld && !out_vld && !rvalid)); // R9

  AST_MASKED_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n && !snooze) |=>
      ($stable(s1_vld) && $stable(s2_vld) && $stable(out_vld))); // R1

  AST_DESELECT_NO_OP: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !snooze && !adv_ld && !(!ce0_n && ce1 && !ce2_n)) |=> !s1_vld); // R2

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!s1_vld && !s2_vld && !out_vld)); // R11

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.DW(LANES*LANE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clk_en_n (clk_en_n),
  .snooze   (snooze),
  .adv_ld   (adv_ld),
  .ce0_n    (ce0_n),
  .ce1      (ce1),
  .ce2_n    (ce2_n),
  .oe_n     (oe_n),
  .rvalid   (rvalid),
  .rdata    (rdata),
  .s1_vld   (s1_q.vld),
  .s2_vld   (s2_q.vld),
  .out_vld  (out_vld_q)
);

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int DW = 18;
  localparam logic [2:0] SEL = 3'b010; // {ce0_n, ce1, ce2_n}

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          clk_en_n = 1'b0, ce0_n = 1'b0, ce1 = 1'b1, ce2_n = 1'b0;
  logic          adv_ld = 1'b0, rd_wr = 1'b1, oe_n = 1'b0, snooze = 1'b0, order_lin = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [1:0]    bwe_n = 2'b00;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  sync_burst_sram dut_i (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .addr(addr),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .adv_ld(adv_ld), .rd_wr(rd_wr),
    .bwe_n(bwe_n), .oe_n(oe_n), .order_lin(order_lin), .snooze(snooze),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int    checks = 0;
  int    errors = 0;
  string req = "R11";

  // ---------------- behavioural reference model ----------------
  typedef struct {
    bit     v;
    bit     w;
    int     a;
    bit [1:0] be;
  } op_t;

  logic [DW-1:0] mm [1<<AW];
  op_t           pq[$];
  bit            m_ov = 0;
  logic [DW-1:0] m_od = '0;
  bit            m_act = 0, m_wr = 0;
  int            m_base = 0, m_step = 0;

  always @(posedge clk) begin : model
    op_t nx, cur;
    if (rst || snooze) begin
      pq.delete();
      m_ov  = 0;
      m_act = 0;
    end else if (!clk_en_n) begin
      m_ov = 0;
      if (pq.size() == 2) begin
        cur = pq.pop_front();
        if (cur.v && cur.w) begin
          for (int l = 0; l < 2; l++)
            if (cur.be[l]) mm[cur.a][l*LW +: LW] = wdata[l*LW +: LW];
        end else if (cur.v) begin
          m_ov = 1;
          m_od = mm[cur.a];
        end
      end
      nx.v = 0; nx.w = 0; nx.a = 0; nx.be = ~bwe_n;
      if (!adv_ld) begin
        nx.v   = (!ce0_n && ce1 && !ce2_n);
        nx.w   = !rd_wr;
        nx.a   = int'(addr);
        m_act  = nx.v;
        m_wr   = nx.w;
        m_base = int'(addr);
        m_step = 0;
      end else if (m_act) begin
        m_step = (m_step + 1) % 4;
        nx.v = 1;
        nx.w = m_wr;
        nx.a = (m_base & ~3) | (order_lin ? ((m_base + m_step) & 3) : ((m_base ^ m_step) & 3));
      end
      pq.push_back(nx);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    @(posedge clk);
    forever begin
      bit            exp_drv;
      logic [DW-1:0] exp_d;
      @(negedge clk);
      #2;
      exp_drv = m_ov && !oe_n && !snooze;
      exp_d   = exp_drv ? m_od : '0;
      chk(rvalid === exp_drv, "rvalid", DW'(rvalid), DW'(exp_drv));
      chk(rdata === exp_d, "rdata", rdata, exp_d);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit cen_n, input bit adv, input bit rw, input logic [2:0] ce,
                     input int a, input logic [1:0] bw);
    clk_en_n = cen_n;
    adv_ld   = adv;
    rd_wr    = rw;
    {ce0_n, ce1, ce2_n} = ce;
    addr     = a[AW-1:0];
    bwe_n    = bw;
    wdata    = DW'($urandom);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 3'b111, 0, 2'b11);
  endtask

  task automatic burst(input bit rw, input int base, input int beats, input bit wild_bw);
    cyc(0, 0, rw, SEL, base, wild_bw ? 2'($urandom) : 2'b00);
    for (int i = 0; i < beats; i++)
      cyc(0, 1, 1'($urandom), 3'($urandom), $urandom, wild_bw ? 2'($urandom) : 2'b00);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R11";
    chk(rvalid == 1'b0, "reset rvalid", DW'(rvalid), '0);
    chk(rdata == '0, "reset rdata", rdata, '0);
    rst = 1'b0;

    req = "R4"; // fill the array with full-word writes
    for (int a = 0; a < (1 << AW); a++) cyc(0, 0, 0, SEL, a, 2'b00);
    idle(3);

    req = "R3";
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, SEL, $urandom, 2'($urandom));
    idle(3);

    req = "R8";
    for (int i = 0; i < 40; i++) begin
      oe_n = 1'($urandom);
      cyc(0, 0, 1, SEL, $urandom, 2'b00);
    end
    oe_n = 1'b0;
    idle(3);

    req = "R4"; // partial lane masks, then read back
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, SEL, i * 7, 2'($urandom));
    for (int i = 0; i < 30; i++) cyc(0, 0, 1, SEL, i * 7, 2'b00);
    idle(3);

    req = "R10"; // write then immediate read of the same word
    for (int i = 0; i < 25; i++) begin
      int a = $urandom % 256;
      cyc(0, 0, 0, SEL, a, 2'($urandom));
      cyc(0, 0, 1, SEL, a, 2'b00);
      cyc(0, 0, 1, SEL, a, 2'b00);
    end
    idle(3);

    req = "R5";
    order_lin = 1'b1;
    for (int i = 0; i < 6; i++) burst(1, $urandom, 6, 0);
    idle(3);

    req = "R6";
    for (int i = 0; i < 8; i++) begin
      order_lin = 1'(i);
      burst(1, $urandom, 7, 0);
    end
    idle(3);

    req = "R7"; // write bursts with a fresh mask per beat, then read back
    for (int i = 0; i < 6; i++) begin
      int b = $urandom % 256;
      order_lin = 1'($urandom);
      burst(0, b, 3, 1);
      burst(1, b, 3, 0);
    end
    idle(3);

    req = "R2"; // every deselecting pattern, with advances after it
    for (int p = 0; p < 8; p++) begin
      if (3'(p) != SEL) begin
        cyc(0, 0, 0, 3'(p), 16 + p, 2'b00);
        cyc(0, 1, 0, SEL, 0, 2'b00);
        cyc(0, 1, 1, SEL, 0, 2'b00);
        cyc(0, 0, 1, SEL, 16 + p, 2'b00);
      end
    end
    idle(3);

    req = "R1"; // masked edges sprinkled into traffic
    for (int i = 0; i < 200; i++)
      cyc(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4 != 0) ? SEL : 3'($urandom),
          $urandom, 2'($urandom));
    idle(3);

    req = "R9"; // snooze in the middle of a write burst and of reads
    for (int i = 0; i < 6; i++) begin
      int b = $urandom % 256;
      cyc(0, 0, 0, SEL, b, 2'b00);
      cyc(0, 1, 0, SEL, 0, 2'b00);
      snooze = 1'b1;
      cyc(0, 0, 0, SEL, b, 2'b00);
      cyc(0, 1, 1, SEL, b, 2'b00);
      snooze = 1'b0;
      cyc(0, 1, 0, SEL, 0, 2'b00);
      cyc(0, 1, 1, SEL, 0, 2'b00);
      burst(1, b, 3, 0);
      idle(3);
    end

    req = "R1"; // long random mix of everything
    for (int i = 0; i < 3000; i++) begin
      snooze    = ($urandom % 40 == 0);
      oe_n      = ($urandom % 8 == 0);
      order_lin = 1'($urandom);
      cyc(($urandom % 5 == 0), 1'($urandom), 1'($urandom),
          ($urandom % 5 != 0) ? SEL : 3'($urandom), $urandom, 2'($urandom));
    end
    snooze = 1'b0;
    oe_n   = 1'b0;
    idle(4);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule